// File: doc/BRIEF.md
# Downward-Growing Stack Pointer Unit

This unit holds the stack pointer of a small processor core and updates it for every stack command the core issues. The stack grows toward lower addresses. Data pushes and pops move the pointer by one byte; subroutine calls, interrupt entries and returns move it by two, since a return address occupies two bytes. For every accepted command the unit also gives the data-memory address the access must use, and whether that access covers one byte or two.

Software sees the pointer as two byte-wide registers, a low byte and a high byte, and can overwrite either of them. After reset the pointer holds the last address of data SRAM. Any command that would carry the pointer into the I/O window at the bottom of the data space (address 0x3F or below, or past either end of the address range) is refused. The pointer then keeps its value and a one-cycle error pulse follows.

Top module: `stack_ptr_unit`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, the pointer reads SRAM_LAST (0x08FF by default) and bound_err is 0.
- R2: Command code 1 (push) writes one byte at the current pointer. In the same cycle mem_en is 1, mem_addr equals the pointer and mem_pair is 0. After the clock edge the pointer is one lower.
- R3: Command code 2 (pop) increments first and then reads. In the same cycle mem_en is 1, mem_addr equals pointer+1 and mem_pair is 0. After the edge the pointer is one higher.
- R4: Command code 3 (call or interrupt entry) stores two bytes. In the same cycle mem_en is 1, mem_pair is 1 and mem_addr equals pointer-1, the lower of the two bytes. After the edge the pointer is two lower.
- R5: Command code 4 (return) loads two bytes. In the same cycle mem_en is 1, mem_pair is 1 and mem_addr equals pointer+1. After the edge the pointer is two higher.
- R6: Codes 0, 5, 6 and 7 are idle: mem_en is 0 and the pointer does not change.
- R7: A command whose result would be 0x3F or below, or would wrap past the top or bottom of the address range, is refused. mem_en is 0, the pointer does not change, and bound_err is 1 in the next cycle only, unless that next cycle also holds a refused command.
- R8: sw_wr_lo replaces bits 7:0 of the pointer with sw_wdata after the edge. The high byte keeps its value.
- R9: sw_wr_hi replaces bits 15:8 of the pointer with sw_wdata after the edge. The low byte keeps its value.
- R10: A software write takes priority. A stack command in the same cycle is ignored: mem_en is 0, no error is raised, and only the written byte changes.
- R11: sp_lo and sp_hi always show bits 7:0 and 15:8 of sp_q.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd | input | 3 | Stack command: 0 idle, 1 push, 2 pop, 3 call, 4 return |
| sw_wr_lo | input | 1 | Software write of the low pointer byte |
| sw_wr_hi | input | 1 | Software write of the high pointer byte |
| sw_wdata | input | 8 | Byte for a software write |
| sp_lo | output | 8 | Low pointer byte for software reads |
| sp_hi | output | 8 | High pointer byte for software reads |
| sp_q | output | ADDR_W | Whole pointer |
| mem_en | output | 1 | A stack access is due this cycle |
| mem_addr | output | ADDR_W | Lowest data address of the access |
| mem_pair | output | 1 | The access covers two bytes (mem_addr and mem_addr+1) |
| bound_err | output | 1 | One-cycle pulse after a refused command |

## Verification
mem_en, mem_addr and mem_pair are combinational, so they are due in the same cycle as the command. The bench samples them one time unit after it drives the inputs on the falling edge. The pointer bytes and bound_err come from registers and change at the next rising edge, so the bench reads them at the falling edge that follows. Consecutive table rows then show both that the error pulse lasts one cycle and that the error repeats when refused commands follow one another.

// File: rtl/sp_pkg.sv
package sp_pkg;

  typedef enum logic [2:0] {
    SPC_IDLE = 3'd0,
    SPC_PUSH = 3'd1,
    SPC_POP  = 3'd2,
    SPC_CALL = 3'd3,
    SPC_RET  = 3'd4
  } sp_cmd_e;

  // any of the four commands that move the pointer
  function automatic logic is_stack_cmd(input logic [2:0] c);
    return (c == SPC_PUSH) || (c == SPC_POP) || (c == SPC_CALL) || (c == SPC_RET);
  endfunction

  // two-byte commands move a return address
  function automatic logic is_pair_cmd(input logic [2:0] c);
    return (c == SPC_CALL) || (c == SPC_RET);
  endfunction

  // commands that store move the pointer downward
  function automatic logic grows_down(input logic [2:0] c);
    return (c == SPC_PUSH) || (c == SPC_CALL);
  endfunction

  function automatic logic [1:0] step_bytes(input logic [2:0] c);
    return is_pair_cmd(c) ? 2'd2 : 2'd1;
  endfunction

endpackage

// File: rtl/sp_step_calc.sv
module sp_step_calc
  import sp_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned IO_TOP = 'h3F
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] sp,
  input  logic [2:0]        cmd,
  output logic [ADDR_W-1:0] next_sp,
  output logic [ADDR_W-1:0] acc_addr,
  output logic              acc_pair,
  output logic              cmd_live,
  output logic              floor_hit
);

  localparam logic [ADDR_W-1:0] FLOOR = ADDR_W'(IO_TOP);

  // result one bit wider so a wrap shows up as a carry or borrow
  function automatic logic [ADDR_W:0] moved(input logic [ADDR_W-1:0] p,
                                            input logic [2:0] c);
    logic [ADDR_W:0] ext;
    logic [ADDR_W:0] st;
    ext = {1'b0, p};
    st  = (ADDR_W+1)'(step_bytes(c));
    return grows_down(c) ? (ext - st) : (ext + st);
  endfunction

  // push stores at the pointer, a call's lower byte sits one below,
  // pops and returns read from one above
  function automatic logic [ADDR_W-1:0] access_at(input logic [ADDR_W-1:0] p,
                                                  input logic [2:0] c);
    if (c == SPC_PUSH)      return p;
    else if (c == SPC_CALL) return p - ADDR_W'(1);
    else                    return p + ADDR_W'(1);
  endfunction

  logic [ADDR_W:0] sum;

  always_comb begin
    sum       = moved(sp, cmd);
    cmd_live  = is_stack_cmd(cmd);
    next_sp   = sum[ADDR_W-1:0];
    floor_hit = cmd_live && (sum[ADDR_W] || (sum[ADDR_W-1:0] <= FLOOR));
    acc_addr  = access_at(sp, cmd);
    acc_pair  = is_pair_cmd(cmd);
  end

  // R3: a pop reads at the address the pointer lands on
  a_r3_pop_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == SPC_POP && !floor_hit) |-> (acc_addr == next_sp));

  // R5: a return reads its lower byte where the pointer was plus one
  a_r5_ret_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == SPC_RET && !floor_hit) |-> (acc_addr == next_sp - ADDR_W'(1)));

endmodule

// File: rtl/sp_sw_port.sv
module sp_sw_port #(
  parameter int unsigned ADDR_W = 16
) (
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic [7:0]        wdata,
  input  logic [ADDR_W-1:0] sp,
  output logic              sw_we,
  output logic [ADDR_W-1:0] sw_value,
  output logic [7:0]        rd_lo,
  output logic [7:0]        rd_hi
);

  localparam int unsigned HI_W   = (ADDR_W > 8) ? ADDR_W - 8 : 1;
  localparam bit          HAS_HI = (ADDR_W > 8);

  assign rd_lo = sp[7:0];

  generate
    if (HAS_HI) begin : g_two_bytes
      assign sw_we = wr_lo | wr_hi;
      always_comb begin
        sw_value = sp;
        if (wr_lo) sw_value[7:0]        = wdata;
        if (wr_hi) sw_value[ADDR_W-1:8] = wdata[HI_W-1:0];
      end
      assign rd_hi = 8'(sp[ADDR_W-1:8]);
    end else begin : g_low_only
      // without a high register its write strobe does nothing
      logic unused_hi;
      assign unused_hi = wr_hi;
      assign sw_we     = wr_lo;
      assign sw_value  = wdata[ADDR_W-1:0];
      assign rd_hi     = 8'h00;
    end
  endgenerate

endmodule

// File: rtl/stack_ptr_unit.sv
module stack_ptr_unit
  import sp_pkg::*;
#(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned SRAM_LAST = 'h08FF,
  parameter int unsigned IO_TOP    = 'h3F
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        cmd,
  input  logic              sw_wr_lo,
  input  logic              sw_wr_hi,
  input  logic [7:0]        sw_wdata,
  output logic [7:0]        sp_lo,
  output logic [7:0]        sp_hi,
  output logic [ADDR_W-1:0] sp_q,
  output logic              mem_en,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_pair,
  output logic              bound_err
);

  localparam logic [ADDR_W-1:0] RESET_SP = ADDR_W'(SRAM_LAST);

  logic [ADDR_W-1:0] next_sp;
  logic [ADDR_W-1:0] acc_addr;
  logic              acc_pair;
  logic              cmd_live;
  logic              floor_hit;
  logic              sw_we;
  logic [ADDR_W-1:0] sw_value;

  // named events for the assertions
  logic step_ok;
  logic step_refused;

  sp_step_calc #(.ADDR_W(ADDR_W), .IO_TOP(IO_TOP)) u_calc (
    .clk      (clk),
    .rst_n    (rst_n),
    .sp       (sp_q),
    .cmd      (cmd),
    .next_sp  (next_sp),
    .acc_addr (acc_addr),
    .acc_pair (acc_pair),
    .cmd_live (cmd_live),
    .floor_hit(floor_hit)
  );

  sp_sw_port #(.ADDR_W(ADDR_W)) u_sw (
    .wr_lo   (sw_wr_lo),
    .wr_hi   (sw_wr_hi),
    .wdata   (sw_wdata),
    .sp      (sp_q),
    .sw_we   (sw_we),
    .sw_value(sw_value),
    .rd_lo   (sp_lo),
    .rd_hi   (sp_hi)
  );

  assign step_ok      = cmd_live && !floor_hit && !sw_we;
  assign step_refused = cmd_live &&  floor_hit && !sw_we;

  assign mem_en   = step_ok;
  assign mem_addr = acc_addr;
  assign mem_pair = step_ok && acc_pair;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sp_q      <= RESET_SP;
      bound_err <= 1'b0;
    end else begin
      bound_err <= step_refused;
      if (sw_we)        sp_q <= sw_value;
      else if (step_ok) sp_q <= next_sp;
    end
  end

  // R1: first cycle out of reset shows the top of SRAM
  a_r1_reset_top: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (sp_q == RESET_SP && !bound_err));

  // R2: a push lowers the pointer by one
  a_r2_push_step: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && cmd == SPC_PUSH) |=> (sp_q == $past(sp_q) - ADDR_W'(1)));

  // R4: a call lowers the pointer by two
  a_r4_call_step: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && cmd == SPC_CALL) |=> (sp_q == $past(sp_q) - ADDR_W'(2)));

  // R6: idle codes leave the pointer alone
  a_r6_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_live && !sw_wr_lo && !sw_wr_hi) |=> $stable(sp_q));

  // R7: a refused command holds the pointer and pulses the error
  a_r7_refuse: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_live && floor_hit && !sw_wr_lo && !sw_wr_hi) |=> ($stable(sp_q) && bound_err));

  // R7: no error without a refused command just before
  a_r7_err_cause: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_live || !floor_hit || sw_wr_lo || sw_wr_hi) |=> !bound_err);

  // R8: low-byte write keeps the high byte
  a_r8_lo_write: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_wr_lo && !sw_wr_hi) |=> (sp_lo == $past(sw_wdata) && $stable(sp_hi)));

  // R10: software access silences the stack port
  a_r10_sw_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_wr_lo || sw_wr_hi) |-> (!mem_en && !mem_pair));

endmodule

// File: tb/stack_ptr_unit_bench.sv
`timescale 1ns/1ps
module stack_ptr_unit_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  cmd = 3'd0;
  logic        sw_wr_lo = 1'b0;
  logic        sw_wr_hi = 1'b0;
  logic [7:0]  sw_wdata = 8'h00;
  logic [7:0]  sp_lo, sp_hi;
  logic [15:0] sp_q, mem_addr;
  logic        mem_en, mem_pair, bound_err;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  stack_ptr_unit u_stack_ptr_unit (
    .clk(clk), .rst_n(rst_n), .cmd(cmd),
    .sw_wr_lo(sw_wr_lo), .sw_wr_hi(sw_wr_hi), .sw_wdata(sw_wdata),
    .sp_lo(sp_lo), .sp_hi(sp_hi), .sp_q(sp_q),
    .mem_en(mem_en), .mem_addr(mem_addr), .mem_pair(mem_pair),
    .bound_err(bound_err)
  );

  typedef struct packed {
    logic [2:0]  c;
    logic        lo;
    logic        hi;
    logic [7:0]  wd;
    logic        en;
    logic [15:0] addr;
    logic        pair;
    logic [15:0] sp;
    logic        err;
  } vec_t;

  localparam int NV = 20;
  // command, sw lo, sw hi, data | due now: en, addr, pair | after edge: sp, err
  localparam vec_t VECS [NV] = '{
    '{3'd1, 1'b0, 1'b0, 8'h00, 1'b1, 16'h08FF, 1'b0, 16'h08FE, 1'b0},
    '{3'd1, 1'b0, 1'b0, 8'h00, 1'b1, 16'h08FE, 1'b0, 16'h08FD, 1'b0},
    '{3'd2, 1'b0, 1'b0, 8'h00, 1'b1, 16'h08FE, 1'b0, 16'h08FE, 1'b0},
    '{3'd3, 1'b0, 1'b0, 8'h00, 1'b1, 16'h08FD, 1'b1, 16'h08FC, 1'b0},
    '{3'd4, 1'b0, 1'b0, 8'h00, 1'b1, 16'h08FD, 1'b1, 16'h08FE, 1'b0},
    '{3'd0, 1'b0, 1'b0, 8'h00, 1'b0, 16'h0000, 1'b0, 16'h08FE, 1'b0},
    '{3'd7, 1'b0, 1'b0, 8'h00, 1'b0, 16'h0000, 1'b0, 16'h08FE, 1'b0},
    '{3'd0, 1'b1, 1'b0, 8'h41, 1'b0, 16'h0000, 1'b0, 16'h0841, 1'b0},
    '{3'd0, 1'b0, 1'b1, 8'h00, 1'b0, 16'h0000, 1'b0, 16'h0041, 1'b0},
    '{3'd1, 1'b0, 1'b0, 8'h00, 1'b1, 16'h0041, 1'b0, 16'h0040, 1'b0},
    '{3'd1, 1'b0, 1'b0, 8'h00, 1'b0, 16'h0000, 1'b0, 16'h0040, 1'b1},
    '{3'd0, 1'b0, 1'b0, 8'h00, 1'b0, 16'h0000, 1'b0, 16'h0040, 1'b0},
    '{3'd3, 1'b0, 1'b0, 8'h00, 1'b0, 16'h0000, 1'b0, 16'h0040, 1'b1},
    '{3'd2, 1'b0, 1'b0, 8'h00, 1'b1, 16'h0041, 1'b0, 16'h0041, 1'b0},
    '{3'd1, 1'b1, 1'b0, 8'h42, 1'b0, 16'h0000, 1'b0, 16'h0042, 1'b0},
    '{3'd0, 1'b0, 1'b1, 8'hFF, 1'b0, 16'h0000, 1'b0, 16'hFF42, 1'b0},
    '{3'd0, 1'b1, 1'b0, 8'hFF, 1'b0, 16'h0000, 1'b0, 16'hFFFF, 1'b0},
    '{3'd2, 1'b0, 1'b0, 8'h00, 1'b0, 16'h0000, 1'b0, 16'hFFFF, 1'b1},
    '{3'd4, 1'b0, 1'b0, 8'h00, 1'b0, 16'h0000, 1'b0, 16'hFFFF, 1'b1},
    '{3'd3, 1'b0, 1'b0, 8'h00, 1'b1, 16'hFFFE, 1'b1, 16'hFFFD, 1'b0}
  };

  function automatic string tag_of(input vec_t v);
    if (v.lo && v.c != 3'd0) return "R10";
    if (v.lo)                return "R8";
    if (v.hi)                return "R9";
    if (v.err)               return "R7";
    case (v.c)
      3'd1:    return "R2";
      3'd2:    return "R3";
      3'd3:    return "R4";
      3'd4:    return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic check(input string tag, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: values held during reset
    check("R1", "sp in reset", sp_q, 16'h08FF);
    check("R1", "err in reset", {15'd0, bound_err}, 16'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "sp after release", sp_q, 16'h08FF);

    for (int i = 0; i < NV; i++) begin
      cmd      = VECS[i].c;
      sw_wr_lo = VECS[i].lo;
      sw_wr_hi = VECS[i].hi;
      sw_wdata = VECS[i].wd;
      #1;
      check(tag_of(VECS[i]), "mem_en", {15'd0, mem_en}, {15'd0, VECS[i].en});
      if (VECS[i].en) begin
        check(tag_of(VECS[i]), "mem_addr", mem_addr, VECS[i].addr);
        check(tag_of(VECS[i]), "mem_pair", {15'd0, mem_pair}, {15'd0, VECS[i].pair});
      end
      @(negedge clk);
      cmd = 3'd0; sw_wr_lo = 1'b0; sw_wr_hi = 1'b0;
      check(tag_of(VECS[i]), "sp", sp_q, VECS[i].sp);
      check(tag_of(VECS[i]), "bound_err", {15'd0, bound_err}, {15'd0, VECS[i].err});
      // R11: byte views follow the pointer
      check("R11", "byte view", {sp_hi, sp_lo}, VECS[i].sp);
    end

    // R1: reset in mid-run returns to the top of SRAM
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "sp after second reset", sp_q, 16'h08FF);
    check("R1", "err after second reset", {15'd0, bound_err}, 16'd0);

    // R9 with R10: high-byte write beats a return in the same cycle
    cmd = 3'd4; sw_wr_hi = 1'b1; sw_wdata = 8'h12;
    #1;
    check("R10", "mem_en during high write", {15'd0, mem_en}, 16'd0);
    @(negedge clk);
    cmd = 3'd0; sw_wr_hi = 1'b0;
    check("R9", "high write keeps low", sp_q, 16'h12FF);
    check("R10", "no error on ignored command", {15'd0, bound_err}, 16'd0);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (2000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule